// File: doc/BRIEF.md
# Banked Program Sequencer with Return Stack

This unit produces the instruction fetch address of a small 4-bit-class controller. A 12-bit counter addresses a location inside a 4 KB bank, and one bank bit picks which half of the 8 KB program space is being fetched. Together they form the 13-bit fetch address. An instruction decoder outside the unit issues one command per clock: hold, step, jump, call, return, return-from-interrupt, bank select or interrupt enable. The unit updates the counter, the bank and a dedicated return stack from that command. The stack holds seven entries in its own registers and never touches program or data memory.

The bank register is written by the bank-select command, but the fetch bank takes its value only when a jump or a call executes. This lets a program change banks at a transfer of control. Plain stepping wraps inside the current bank. A single maskable interrupt line, when enabled, replaces the current command with an entry sequence. That sequence saves the address that would have been fetched, turns interrupts off and fetches from a fixed vector in bank 0.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the fetch address is 0 in bank 0, the bank register reads 0, interrupts are disabled, the overflow flag is clear and the return stack is empty, so a return (command 4) fetches address 0 in bank 0.
- R2: Command 1 (step) advances the 12-bit in-bank address by 2 when `step2_i` is 1 and by 1 otherwise, wrapping from 0xFFF to 0x000 without changing the fetch bank.
- R3: Command 2 (jump) loads `target_i` as the in-bank address on the next clock, and the fetch bank becomes the bank register's value.
- R4: Command 6 (bank select) loads `sel_i` into the bank register, which shows on `bank_sel_o` one clock later. The fetch bank (bit 12 of `fetch_addr_o`) is unchanged until the next jump or call, and steps never alter it.
- R5: Command 3 (call) pushes {current fetch bank, in-bank address + 2}, then jumps as in R3. Command 4 (return) pops the top entry into the fetch bank and the in-bank address.
- R6: The stack holds 7 entries: seven nested calls followed by seven returns come back in last-in, first-out order.
- R7: A push with 7 entries held discards the oldest entry and sets `stack_ovf_o`, which stays set until reset. A pop from an empty stack fetches address 0 in bank 0.
- R8: Command 7 loads `sel_i` into the interrupt enable, shown on `irq_en_o`. While the enable is 0, `irq_i` has no effect and the command runs normally.
- R9: When `irq_i` is 1 and the enable is 1, the command is ignored. The current fetch address is pushed, the enable is cleared, the fetch address becomes `VECTOR` (default 0x003) in bank 0, and the bank register is unchanged.
- R10: Command 5 (return from interrupt) pops as in R5 and sets the interrupt enable to 1.
- R11: Command 0 (hold) leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Command code, one per clock |
| target_i | input | 12 | In-bank destination for jump and call |
| sel_i | input | 1 | Value for bank select and interrupt enable commands |
| step2_i | input | 1 | Step size: 1 selects a two-byte advance |
| irq_i | input | 1 | Maskable interrupt request |
| fetch_addr_o | output | 13 | Fetch address: bit 12 is the bank, bits 11:0 the in-bank address |
| bank_sel_o | output | 1 | Bank register contents |
| irq_en_o | output | 1 | Interrupt enable |
| stack_ovf_o | output | 1 | Sticky return-stack overflow flag |

## Verification
The hardest state to reach is a full stack that wraps round. An eighth push has to evict the oldest entry, and the following returns must unwind the seven survivors and then find the stack empty. A directed run of eight nested calls, each from a distinct bank and address, followed by eight returns, drives this case against a queue model that drops its front entry when full. An interrupt that arrives on a jump while the bank register differs from the fetch bank is also steered explicitly. This shows that the vector entry ignores both the command and the bank register.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD = 3'd0,
        CMD_STEP = 3'd1,
        CMD_JUMP = 3'd2,
        CMD_CALL = 3'd3,
        CMD_RET  = 3'd4,
        CMD_RETI = 3'd5,
        CMD_BANK = 3'd6,
        CMD_IEN  = 3'd7
    } cmd_e;
endpackage

// File: rtl/pc_seq_stack.sv
module pc_seq_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           top;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t          stk_q, stk_d;
    logic [PW-1:0] last_idx;
    logic [PW-1:0] next_idx;

    always_comb begin
        stk_d    = stk_q;
        last_idx = (stk_q.top == '0) ? PW'(DEPTH - 1) : stk_q.top - PW'(1);
        next_idx = (stk_q.top == PW'(DEPTH - 1)) ? '0 : stk_q.top + PW'(1);
        full     = (stk_q.cnt == CW'(DEPTH));
        top_data = (stk_q.cnt != '0) ? stk_q.mem[last_idx] : '0;
        if (push) begin
            stk_d.mem[stk_q.top] = push_data;
            stk_d.top            = next_idx;
            if (!full) stk_d.cnt = stk_q.cnt + CW'(1);
        end else if (pop && stk_q.cnt != '0) begin
            stk_d.top = last_idx;
            stk_d.cnt = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end
endmodule

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
    import pc_seq_pkg::*;
#(
    parameter int              PC_W   = 12,
    parameter logic [PC_W-1:0] VECTOR = 12'h003
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [PC_W-1:0] target,
    input  logic            sel,
    input  logic            step2,
    input  logic            irq,
    input  logic [PC_W:0]   stk_top,
    input  logic            stk_full,
    output logic            push,
    output logic            pop,
    output logic [PC_W:0]   push_data,
    output logic [PC_W:0]   fetch_addr,
    output logic            bank_sel,
    output logic            irq_en,
    output logic            ovf
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            act;
        logic            sel;
        logic            ie;
        logic            ovf;
    } seq_t;

    seq_t            seq_q, seq_d;
    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_d     = seq_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = {seq_q.act, seq_q.pc};
        seq_pc    = seq_q.pc + (step2 ? PC_W'(2) : PC_W'(1));
        if (irq && seq_q.ie) begin
            push      = 1'b1;
            seq_d.pc  = VECTOR;
            seq_d.act = 1'b0;
            seq_d.ie  = 1'b0;
            if (stk_full) seq_d.ovf = 1'b1;
        end else begin
            unique case (cmd)
                CMD_STEP: seq_d.pc = seq_pc;
                CMD_JUMP: begin
                    seq_d.pc  = target;
                    seq_d.act = seq_q.sel;
                end
                CMD_CALL: begin
                    push      = 1'b1;
                    push_data = {seq_q.act, seq_q.pc + PC_W'(2)};
                    seq_d.pc  = target;
                    seq_d.act = seq_q.sel;
                    if (stk_full) seq_d.ovf = 1'b1;
                end
                CMD_RET: begin
                    pop                  = 1'b1;
                    {seq_d.act, seq_d.pc} = stk_top;
                end
                CMD_RETI: begin
                    pop                  = 1'b1;
                    {seq_d.act, seq_d.pc} = stk_top;
                    seq_d.ie             = 1'b1;
                end
                CMD_BANK: seq_d.sel = sel;
                CMD_IEN:  seq_d.ie  = sel;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign fetch_addr = {seq_q.act, seq_q.pc};
    assign bank_sel   = seq_q.sel;
    assign irq_en     = seq_q.ie;
    assign ovf        = seq_q.ovf;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int              PC_W   = 12,
    parameter int              DEPTH  = 7,
    parameter logic [PC_W-1:0] VECTOR = 12'h003
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cmd_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            sel_i,
    input  logic            step2_i,
    input  logic            irq_i,
    output logic [PC_W:0]   fetch_addr_o,
    output logic            bank_sel_o,
    output logic            irq_en_o,
    output logic            stack_ovf_o
);
    localparam int AW = PC_W + 1;

    logic          push, pop, stk_full;
    logic [AW-1:0] push_data, stk_top;

    pc_seq_ctrl #(.PC_W(PC_W), .VECTOR(VECTOR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd_e'(cmd_i)),
        .target     (target_i),
        .sel        (sel_i),
        .step2      (step2_i),
        .irq        (irq_i),
        .stk_top    (stk_top),
        .stk_full   (stk_full),
        .push       (push),
        .pop        (pop),
        .push_data  (push_data),
        .fetch_addr (fetch_addr_o),
        .bank_sel   (bank_sel_o),
        .irq_en     (irq_en_o),
        .ovf        (stack_ovf_o)
    );

    pc_seq_stack #(.W(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (stk_top),
        .full      (stk_full)
    );
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int              PC_W   = 12,
    parameter logic [PC_W-1:0] VECTOR = 12'h003
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      cmd_i,
    input logic [PC_W-1:0] target_i,
    input logic            step2_i,
    input logic            irq_i,
    input logic [PC_W:0]   fetch_addr_o,
    input logic            bank_sel_o,
    input logic            irq_en_o,
    input logic            stack_ovf_o
);
    logic take_irq;
    assign take_irq = irq_i && irq_en_o;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_addr_o == '0 && !irq_en_o && !bank_sel_o && !stack_ovf_o));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && !take_irq) |=>
        fetch_addr_o[PC_W-1:0] == $past(fetch_addr_o[PC_W-1:0]) + ($past(step2_i) ? PC_W'(2) : PC_W'(1)));

    assert_step_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && !take_irq) |=> $stable(fetch_addr_o[PC_W]));

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd2 && !take_irq) |=> fetch_addr_o == {$past(bank_sel_o), $past(target_i)});

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf_o |=> stack_ovf_o);

    assert_irq_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (fetch_addr_o == {1'b0, VECTOR} && !irq_en_o && $stable(bank_sel_o)));

    assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_o && cmd_i == 3'd0) |=> $stable(fetch_addr_o));
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd_i),
    .target_i     (target_i),
    .step2_i      (step2_i),
    .irq_i        (irq_i),
    .fetch_addr_o (fetch_addr_o),
    .bank_sel_o   (bank_sel_o),
    .irq_en_o     (irq_en_o),
    .stack_ovf_o  (stack_ovf_o)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = 3'd0;
    logic [11:0] target_i = '0;
    logic        sel_i = 1'b0, step2_i = 1'b0, irq_i = 1'b0;
    logic [12:0] fetch_addr_o;
    logic        bank_sel_o, irq_en_o, stack_ovf_o;

    int checks = 0;
    int errors = 0;

    int m_pc = 0, m_act = 0, m_sel = 0, m_ie = 0, m_ovf = 0;
    int stk[$];

    always #4 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .target_i(target_i),
        .sel_i(sel_i), .step2_i(step2_i), .irq_i(irq_i),
        .fetch_addr_o(fetch_addr_o), .bank_sel_o(bank_sel_o),
        .irq_en_o(irq_en_o), .stack_ovf_o(stack_ovf_o)
    );

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic compare(input string req);
        int got, exp;
        got = {16'd0, fetch_addr_o, bank_sel_o, irq_en_o, stack_ovf_o};
        exp = (m_act << 15) | (m_pc << 3) | (m_sel << 2) | (m_ie << 1) | m_ovf;
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%04h expected=%04h (addr,bank,ie,ovf)", req, got, exp);
        end
    endtask

    task automatic m_push(input int v);
        if (stk.size() == 7) begin
            void'(stk.pop_front());
            m_ovf = 1;
        end
        stk.push_back(v);
    endtask

    task automatic m_pop();
        int v;
        v = (stk.size() > 0) ? stk.pop_back() : 0;
        m_act = (v >> 12) & 1;
        m_pc  = v & 12'hFFF;
    endtask

    task automatic cyc(input int c, input int tgt, input bit s, input bit st2,
                       input bit irq, input string req);
        cmd_i = 3'(c); target_i = 12'(tgt); sel_i = s; step2_i = st2; irq_i = irq;
        @(posedge clk);
        if (irq && m_ie == 1) begin
            m_push((m_act << 12) | m_pc);
            m_pc = 12'h003; m_act = 0; m_ie = 0;
        end else begin
            case (c)
                1: m_pc = (m_pc + (st2 ? 2 : 1)) & 12'hFFF;
                2: begin m_pc = tgt & 12'hFFF; m_act = m_sel; end
                3: begin
                    m_push((m_act << 12) | ((m_pc + 2) & 12'hFFF));
                    m_pc = tgt & 12'hFFF; m_act = m_sel;
                end
                4: m_pop();
                5: begin m_pop(); m_ie = 1; end
                6: m_sel = s;
                7: m_ie = s;
                default: ;
            endcase
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        cyc(2, 12'h100, 0, 0, 0, "R3 jump");
        cyc(4, 0, 0, 0, 0, "R1 empty stack return");
        // R2 stepping and wrap
        cyc(1, 0, 0, 0, 0, "R2 step 1");
        cyc(1, 0, 0, 1, 0, "R2 step 2");
        cyc(2, 12'hFFE, 0, 0, 0, "R3 jump near top");
        cyc(1, 0, 0, 1, 0, "R2 wrap");
        cyc(0, 0, 0, 0, 0, "R11 hold");
        // R4 bank select is deferred
        cyc(6, 0, 1, 0, 0, "R4 bank select");
        cyc(1, 0, 0, 0, 0, "R4 step keeps fetch bank");
        cyc(2, 12'h200, 0, 0, 0, "R4 jump applies bank");
        cyc(2, 12'hFFF, 0, 0, 0, "R3 jump bank 1");
        cyc(1, 0, 0, 0, 0, "R2 wrap bank 1");
        // R5 call and return across banks
        cyc(3, 12'h400, 0, 0, 0, "R5 call");
        cyc(6, 0, 0, 0, 0, "R4 select bank 0");
        cyc(3, 12'h050, 0, 0, 0, "R5 call into bank 0");
        cyc(4, 0, 0, 0, 0, "R5 return to bank 1");
        cyc(4, 0, 0, 0, 0, "R5 second return");
        // R6/R7 depth, overflow, underflow
        for (int i = 0; i < 8; i++) begin
            cyc(6, 0, bit'(i & 1), 0, 0, "R4 alternate bank");
            cyc(3, 16 * i + 5, 0, 0, 0, (i == 7) ? "R7 eighth call overflows" : "R6 nested call");
        end
        for (int i = 0; i < 8; i++)
            cyc(4, 0, 0, 0, 0, (i == 7) ? "R7 pop from empty" : "R6 LIFO return");
        // R8/R9/R10 interrupts
        cyc(1, 0, 0, 0, 1, "R8 masked request");
        cyc(7, 0, 1, 0, 0, "R8 enable");
        cyc(6, 0, 1, 0, 0, "R4 bank select before irq");
        cyc(2, 12'h777, 0, 0, 1, "R9 interrupt entry");
        cyc(1, 0, 0, 0, 1, "R9 no re-entry while disabled");
        cyc(5, 0, 0, 0, 0, "R10 return from interrupt");
        cyc(7, 0, 0, 0, 1, "R8 disable wins over nothing");
        cyc(1, 0, 0, 0, 1, "R8 request ignored");
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            int c;
            c = int'($urandom_range(0, 7));
            case (c)
                0: cyc(c, 0, 0, 0, ($urandom_range(0, 9) == 0), "R11 random hold");
                1: cyc(c, 0, 0, bit'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0), "R2 random step");
                2: cyc(c, int'($urandom_range(0, 4095)), 0, 0, ($urandom_range(0, 9) == 0), "R3 random jump");
                3: cyc(c, int'($urandom_range(0, 4095)), 0, 0, ($urandom_range(0, 9) == 0), "R5 random call");
                4: cyc(c, 0, 0, 0, ($urandom_range(0, 9) == 0), "R5 random return");
                5: cyc(c, 0, 0, 0, ($urandom_range(0, 9) == 0), "R10 random reti");
                6: cyc(c, 0, bit'($urandom_range(0, 1)), 0, ($urandom_range(0, 9) == 0), "R4 random bank");
                default: cyc(c, 0, bit'($urandom_range(0, 1)), 0, ($urandom_range(0, 9) == 0), "R8 random enable");
            endcase
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule